// File: doc/BRIEF.md
# Delay-Line Frequency Range and Lock Sequencer

This block sets up the delay-locked loop of an eMMC interface PHY for a new card clock rate. A single start pulse comes with the card clock frequency, given as an integer number of MHz and already rounded to the nearest value. Below a bypass threshold of 50 MHz the loop cannot lock. In that case the block turns the loop off and routes both the transmit and receive timing through the fixed delay chain. The sequence then finishes in one cycle.

At 50 MHz or above the block runs a fixed sequence. It stops the card clock, turns the loop off, deselects the delay chain and loads a 3-bit range code. One cycle later it turns the loop on. It then waits for the ready flag that the PHY raises on lock. The wait is bounded by a cycle count. When the wait runs out, a sticky timeout flag is set and the loop is turned off again.

Top module: `dll_range_ctrl`

## Requirements
- R1: After reset, `dll_en_o`, `dly_tx_sel_o`, `dly_rx_sel_o`, `done_o` and `timeout_o` are 0, `card_clk_en_o` is 1 and `freq_sel_o` is 4.
- R2: The range code follows the frequency f in MHz:
  - 0 when 170 < f <= 200.
  - 1 when 140 < f <= 170.
  - 2 when 110 < f <= 140.
  - 3 when 80 < f <= 110.
  - 4 for any other f of at least 50.
- R3: The codes 5, 6 and 7 are reserved and never appear on `freq_sel_o`. A frequency above 200 MHz gives code 4.
- R4: If start is accepted with f < 50, then in the next cycle:
  - `dly_tx_sel_o` and `dly_rx_sel_o` are 1.
  - `dll_en_o` is 0.
  - `done_o` is 1 and `card_clk_en_o` is 1.
  - `freq_sel_o` keeps its previous value.
- R5: If start is accepted with f >= 50, then in the next cycle:
  - `card_clk_en_o`, `dll_en_o`, both delay-chain selects and `done_o` are 0.
  - `freq_sel_o` holds the R2 code.
- R6: One cycle after the R5 cycle, `dll_en_o` becomes 1 and the lock wait begins.
- R7: During the lock wait, a `dll_rdy_i` sampled high sets `done_o` and `card_clk_en_o` to 1 in the next cycle, and `dll_en_o` stays 1.
- R8: If `dll_rdy_i` stays low for TIMEOUT_CYC wait cycles, then in the cycle that follows the last of them:
  - `timeout_o` becomes 1.
  - `dll_en_o` becomes 0.
  - `done_o` and `card_clk_en_o` stay 0.
- R9: `timeout_o` and `done_o` hold their value until the next accepted start, which clears both.
- R10: A start pulse during the setup cycle or the lock wait is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted only when the block is idle |
| freq_mhz_i | input | FREQ_W | Card clock frequency in MHz, sampled together with start |
| dll_rdy_i | input | 1 | Lock ready flag from the PHY |
| card_clk_en_o | output | 1 | Card clock enable |
| dll_en_o | output | 1 | Delay-locked loop enable |
| freq_sel_o | output | 3 | Frequency range code for the loop |
| dly_tx_sel_o | output | 1 | Selects the delay chain for transmit timing |
| dly_rx_sel_o | output | 1 | Selects the delay chain for receive timing |
| done_o | output | 1 | Sequence finished successfully (sticky) |
| timeout_o | output | 1 | Lock wait expired (sticky) |

## Verification
Several properties are checked on every cycle:
- The reserved codes never appear on `freq_sel_o`.
- The loop enable and a delay-chain select are never high together.
- `done_o` and `timeout_o` are never high together.
- The loop is switched on only while the card clock is stopped and the delay chain is deselected.
- A successful finish on the loop path is always preceded by a sampled ready flag.
- The timeout flag stays set until a start.

Some behaviour can only be shown by the bench's scenarios:
- The exact code for each range edge.
- The one-cycle spacing of the setup steps.
- The exact length of the timeout window.
- That a start pulse arriving while the block is busy is ignored.

// File: rtl/dllc_pkg.sv
package dllc_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_PREP = 2'd1,
        PH_WAIT = 2'd2
    } phase_e;

    typedef struct packed {
        phase_e     phase;
        logic       clk_en;
        logic       dll_en;
        logic       dly_sel;
        logic [2:0] fsel;
        logic [2:0] pend_code;
        logic       done;
        logic       tmo;
    } ctrl_s;

    localparam logic [2:0] CODE_LOW = 3'd4;
endpackage

// File: rtl/dllc_range_enc.sv
module dllc_range_enc #(
    parameter int FREQ_W     = 9,
    parameter int BYPASS_MHZ = 50
) (
    input  logic [FREQ_W-1:0] freq_i,
    output logic [2:0]        code_o,
    output logic              bypass_o
);
    localparam int unsigned EDGE0 = 200;
    localparam int unsigned EDGE1 = 170;
    localparam int unsigned EDGE2 = 140;
    localparam int unsigned EDGE3 = 110;
    localparam int unsigned EDGE4 = 80;

    logic [31:0] fv;
    assign fv = 32'(freq_i);

    always_comb begin
        bypass_o = (fv < 32'(BYPASS_MHZ));
        if (fv > EDGE1 && fv <= EDGE0)      code_o = 3'd0;
        else if (fv > EDGE2 && fv <= EDGE1) code_o = 3'd1;
        else if (fv > EDGE3 && fv <= EDGE2) code_o = 3'd2;
        else if (fv > EDGE4 && fv <= EDGE3) code_o = 3'd3;
        else                                code_o = dllc_pkg::CODE_LOW;
    end
endmodule

// File: rtl/dllc_lock_timer.sv
module dllc_lock_timer #(
    parameter int TIMEOUT_CYC = 20_000_000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clr_i,
    input  logic run_i,
    output logic expire_o
);
    localparam int CNT_W = (TIMEOUT_CYC > 2) ? $clog2(TIMEOUT_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYC - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)      cnt_d = '0;
        else if (run_i) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign expire_o = run_i && !clr_i && (cnt_q == LAST);
endmodule

// File: rtl/dll_range_ctrl.sv
module dll_range_ctrl #(
    parameter int FREQ_W      = 9,
    parameter int BYPASS_MHZ  = 50,
    parameter int TIMEOUT_CYC = 20_000_000
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic [FREQ_W-1:0] freq_mhz_i,
    input  logic              dll_rdy_i,
    output logic              card_clk_en_o,
    output logic              dll_en_o,
    output logic [2:0]        freq_sel_o,
    output logic              dly_tx_sel_o,
    output logic              dly_rx_sel_o,
    output logic              done_o,
    output logic              timeout_o
);
    import dllc_pkg::*;

    ctrl_s      st_d, st_q;
    logic [2:0] code;
    logic       bypass;
    logic       tmr_clr, tmr_run, tmr_exp;

    dllc_range_enc #(
        .FREQ_W    (FREQ_W),
        .BYPASS_MHZ(BYPASS_MHZ)
    ) u_enc (
        .freq_i  (freq_mhz_i),
        .code_o  (code),
        .bypass_o(bypass)
    );

    assign tmr_clr = (st_q.phase == PH_PREP);
    assign tmr_run = (st_q.phase == PH_WAIT) && !dll_rdy_i;

    dllc_lock_timer #(
        .TIMEOUT_CYC(TIMEOUT_CYC)
    ) u_tmr (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clr_i   (tmr_clr),
        .run_i   (tmr_run),
        .expire_o(tmr_exp)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    st_d.done = 1'b0;
                    st_d.tmo  = 1'b0;
                    st_d.dll_en = 1'b0;
                    if (bypass) begin
                        st_d.dly_sel = 1'b1;
                        st_d.clk_en  = 1'b1;
                        st_d.done    = 1'b1;
                    end else begin
                        st_d.clk_en    = 1'b0;
                        st_d.dly_sel   = 1'b0;
                        st_d.fsel      = code;
                        st_d.pend_code = code;
                        st_d.phase     = PH_PREP;
                    end
                end
            end
            PH_PREP: begin
                st_d.dll_en = 1'b1;
                st_d.phase  = PH_WAIT;
            end
            PH_WAIT: begin
                if (dll_rdy_i) begin
                    st_d.done   = 1'b1;
                    st_d.clk_en = 1'b1;
                    st_d.phase  = PH_IDLE;
                end else if (tmr_exp) begin
                    st_d.tmo    = 1'b1;
                    st_d.dll_en = 1'b0;
                    st_d.phase  = PH_IDLE;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{phase: PH_IDLE, clk_en: 1'b1, dll_en: 1'b0, dly_sel: 1'b0,
                      fsel: CODE_LOW, pend_code: CODE_LOW, done: 1'b0, tmo: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign card_clk_en_o = st_q.clk_en;
    assign dll_en_o      = st_q.dll_en;
    assign freq_sel_o    = st_q.fsel;
    assign dly_tx_sel_o  = st_q.dly_sel;
    assign dly_rx_sel_o  = st_q.dly_sel;
    assign done_o        = st_q.done;
    assign timeout_o     = st_q.tmo;
endmodule

// File: rtl/dll_range_ctrl_chk.sv
module dll_range_ctrl_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       start_i,
    input logic       dll_rdy_i,
    input logic       card_clk_en_o,
    input logic       dll_en_o,
    input logic [2:0] freq_sel_o,
    input logic       dly_tx_sel_o,
    input logic       dly_rx_sel_o,
    input logic       done_o,
    input logic       timeout_o
);
    p_no_reserved_code_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        freq_sel_o <= 3'd4);

    p_loop_or_chain_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(dll_en_o && (dly_tx_sel_o || dly_rx_sel_o)));

    p_enable_after_prep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(dll_en_o) |-> (!card_clk_en_o && !dly_tx_sel_o && !dly_rx_sel_o && !done_o));

    p_done_needs_ready_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(done_o) && dll_en_o) |-> $past(dll_rdy_i));

    p_done_xor_timeout_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(done_o && timeout_o));

    p_timeout_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (timeout_o && !start_i) |=> timeout_o);
endmodule

bind dll_range_ctrl dll_range_ctrl_chk u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .dll_rdy_i    (dll_rdy_i),
    .card_clk_en_o(card_clk_en_o),
    .dll_en_o     (dll_en_o),
    .freq_sel_o   (freq_sel_o),
    .dly_tx_sel_o (dly_tx_sel_o),
    .dly_rx_sel_o (dly_rx_sel_o),
    .done_o       (done_o),
    .timeout_o    (timeout_o)
);

// File: tb/dll_range_ctrl_tb.sv
module dll_range_ctrl_tb_top;
    localparam int FREQ_W = 9;
    localparam int TMO    = 16;
    localparam int NVEC   = 15;

    // vector layout: {freq[8:0], code[2:0], bypass}
    localparam logic [12:0] VEC [NVEC] = '{
        {9'd200, 3'd0, 1'b0}, {9'd171, 3'd0, 1'b0}, {9'd170, 3'd1, 1'b0},
        {9'd141, 3'd1, 1'b0}, {9'd140, 3'd2, 1'b0}, {9'd111, 3'd2, 1'b0},
        {9'd110, 3'd3, 1'b0}, {9'd81,  3'd3, 1'b0}, {9'd80,  3'd4, 1'b0},
        {9'd50,  3'd4, 1'b0}, {9'd201, 3'd4, 1'b0}, {9'd275, 3'd4, 1'b0},
        {9'd511, 3'd4, 1'b0}, {9'd49,  3'd4, 1'b1}, {9'd0,   3'd4, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [FREQ_W-1:0] freq = '0;
    logic rdy = 1'b0;
    logic clk_en, dll_en, tx_sel, rx_sel, done, tmo;
    logic [2:0] fsel;
    int n_chk = 0;
    int n_fail = 0;
    logic [2:0] last_code;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    dll_range_ctrl #(
        .FREQ_W(FREQ_W), .BYPASS_MHZ(50), .TIMEOUT_CYC(TMO)
    ) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .freq_mhz_i(freq),
        .dll_rdy_i(rdy), .card_clk_en_o(clk_en), .dll_en_o(dll_en),
        .freq_sel_o(fsel), .dly_tx_sel_o(tx_sel), .dly_rx_sel_o(rx_sel),
        .done_o(done), .timeout_o(tmo)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_start(logic [FREQ_W-1:0] f);
        @(negedge clk); start = 1'b1; freq = f;
        @(negedge clk); start = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 dll_en", 32'(dll_en), 0);
        chk("R1 dly_sel", 32'({tx_sel, rx_sel}), 0);
        chk("R1 done/tmo", 32'({done, tmo}), 0);
        chk("R1 clk_en", 32'(clk_en), 1);
        chk("R1 fsel", 32'(fsel), 4);
        rst_n = 1'b1;
        last_code = 3'd4;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            pulse_start(VEC[i][12:4]);
            if (VEC[i][0]) begin
                // R4: bypass path
                chk("R4 dly_sel", 32'({tx_sel, rx_sel}), 3);
                chk("R4 dll_en", 32'(dll_en), 0);
                chk("R4 done", 32'({done, clk_en}), 3);
                chk("R4 fsel kept", 32'(fsel), 32'(last_code));
            end else begin
                // R5/R2/R3: setup cycle
                chk("R2 R3 code", 32'(fsel), 32'(VEC[i][3:1]));
                chk("R5 prep", 32'({clk_en, dll_en, tx_sel, rx_sel, done}), 0);
                @(negedge clk);
                chk("R6 dll_en", 32'(dll_en), 1);
                rdy = 1'b1;
                @(negedge clk);
                rdy = 1'b0;
                chk("R7 done", 32'({done, clk_en, dll_en, tmo}), 32'hE);
                last_code = VEC[i][3:1];
            end
            @(negedge clk);
        end

        // R8: timeout window, R10: start ignored while waiting
        pulse_start(9'd150);
        @(negedge clk);
        chk("R6 dll_en", 32'(dll_en), 1);
        start = 1'b1; freq = 9'd20;
        @(negedge clk);
        start = 1'b0;
        chk("R10 ignored", 32'({tx_sel, dll_en, fsel}), 32'({1'b0, 1'b1, 3'd1}));
        repeat (TMO - 2) @(negedge clk);
        chk("R8 not yet", 32'({tmo, dll_en}), 32'b01);
        @(negedge clk);
        chk("R8 timeout", 32'({tmo, dll_en, done, clk_en}), 32'b1000);
        rdy = 1'b1;
        repeat (3) @(negedge clk);
        rdy = 1'b0;
        chk("R9 sticky", 32'({tmo, done}), 32'b10);

        // R9: start clears timeout
        pulse_start(9'd30);
        chk("R9 cleared", 32'({tmo, done}), 32'b01);

        // R9: done sticky after lock, cleared by next start
        pulse_start(9'd100);
        chk("R9 done cleared", 32'(done), 0);
        @(negedge clk);
        rdy = 1'b1;
        @(negedge clk);
        rdy = 1'b0;
        repeat (4) @(negedge clk);
        chk("R9 done held", 32'({done, fsel}), 32'({1'b1, 3'd3}));

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule